// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block gives software control over a set of up to 32 general-purpose pins through a small word-addressed register bus. Each pin can be set as an input or an output. Output pins drive a level held in a register. Input pins are sampled through a two-stage synchroniser, and software reads the sampled level back.

Each pin also has an interrupt source. It can be set to fire on a steady high or low level, on a rising or falling transition, or on every transition. Each source sets a sticky status bit. The status bit is masked by a per-pin enable to form a pending bit. All pending bits are ORed into one interrupt line to the host. Software acknowledges a source by writing ones to a clear register.

The register bus has one-cycle writes. A read returns its data on the cycle after the request. Register offsets are byte addresses on a word grid, and bit n of each per-pin register controls pin n.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the registers hold these values:
  - direction: all ones (every pin an input)
  - output level: zero
  - interrupt enable: zero
  - trigger-kind select: all ones (edge)
  - polarity: all ones
  - both-transitions select: zero
  - status: zero
  
  With these values `pin_oe` is zero and `irq_o` is low.
- R2: Direction register (offset 0x04): a 1 makes the pin an input and a 0 makes it an output. `pin_oe` is the inverse of this register. `pin_out` shows the output-level register (offset 0x00) on the cycle after a write to it.
- R3: A read of offset 0x00 returns the synchronised pad level for input pins and the driven level for output pins. The synchronised level reflects `pin_in` two clock edges after it changes.
- R4: When the trigger-kind bit (offset 0x18) is 0, the pin is level-triggered. Its status bit is set on every cycle that the synchronised level equals the polarity bit (offset 0x1C): 1 means active-high, 0 means active-low.
- R5: When the trigger-kind bit is 1 and the both-transitions bit (offset 0x24) is 0, the status bit is set on a 0-to-1 transition if polarity is 1, or on a 1-to-0 transition if polarity is 0.
- R6: When the trigger-kind bit and the both-transitions bit are both 1, the status bit is set on every transition, whatever the polarity bit holds.
- R7: Writing a 1 to a bit of the clear register (offset 0x14) clears that status bit. A 0 leaves the bit unchanged. A level source that is still active reads back as set after a clear.
- R8: If a clear and a new trigger hit the same pin in the same cycle, the status bit stays set.
- R9: The pending register (offset 0x10) reads status AND enable (offset 0x08). `irq_o` is high exactly when some pending bit is 1.
- R10: Offset 0x20 reads the version constant. Its default is 3, which marks that the both-transitions register exists. Writes to the version, status (0x0C) and pending offsets change nothing.
- R11: A read request is answered on the next cycle. A read of any address other than the ten listed offsets returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pin_in | input | NUM_PINS | Pad levels into the block |
| pin_out | output | NUM_PINS | Levels driven to pads |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Trigger detection is tried in six configurations: active-high level, active-low level, rising, falling, and all-transitions with each polarity value. Each configuration is run against start/end pin patterns that give every pin a rise, a fall, a steady high or a steady low. A wrong polarity, a missing edge or a confused level/edge decode therefore shows up as a different status word.

The enable mask is swept over several patterns against a fixed status word, so that pending masking is separated from the OR into `irq_o`. A clear that lands on the same cycle as a fresh edge is timed exactly, which tells apart the two possible priorities between clearing and setting.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_LEVEL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_KIND  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_POL   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_VER   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 6'h24;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] lvl,
  output logic [NUM_PINS-1:0] lvl_prev
);
  logic [NUM_PINS-1:0] meta_q;
  logic [NUM_PINS-1:0] lvl_q;
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl      = lvl_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] lvl_prev,
  input  logic [NUM_PINS-1:0] kind_edge,
  input  logic [NUM_PINS-1:0] pol_high,
  input  logic [NUM_PINS-1:0] both_edge,
  output logic [NUM_PINS-1:0] hit
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, lvl_act, edge_act;
    always_comb begin
      rise     = lvl[i] & ~lvl_prev[i];
      fall     = ~lvl[i] & lvl_prev[i];
      lvl_act  = pol_high[i] ? lvl[i] : ~lvl[i];
      if (both_edge[i]) edge_act = rise | fall;
      else              edge_act = pol_high[i] ? rise : fall;
      hit[i]   = kind_edge[i] ? edge_act : lvl_act;
    end
  end
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] hit,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic [NUM_PINS-1:0] ien,
  output logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] pending,
  output logic                irq
);
  logic [NUM_PINS-1:0] status_q, status_n;

  // A set on the same cycle as a clear takes priority.
  always_comb status_n = (status_q & ~clr_mask) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_n;
  end

  assign status  = status_q;
  assign pending = status_q & ien;
  assign irq     = |pending;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int          NUM_PINS = 32,
  parameter int unsigned VERSION  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] status,
  input  logic [NUM_PINS-1:0] pending,
  output logic [NUM_PINS-1:0] dir_in,
  output logic [NUM_PINS-1:0] out_lvl,
  output logic [NUM_PINS-1:0] ien,
  output logic [NUM_PINS-1:0] kind_edge,
  output logic [NUM_PINS-1:0] pol_high,
  output logic [NUM_PINS-1:0] both_edge,
  output logic [NUM_PINS-1:0] clr_mask
);
  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] dir_q,  dir_n;
  logic [NUM_PINS-1:0] out_q,  out_n;
  logic [NUM_PINS-1:0] ien_q,  ien_n;
  logic [NUM_PINS-1:0] kind_q, kind_n;
  logic [NUM_PINS-1:0] pol_q,  pol_n;
  logic [NUM_PINS-1:0] both_q, both_n;
  logic [BUS_W-1:0]    rd_mux;
  logic [BUS_W-1:0]    rdata_q;

  assign wd = bus_wdata[NUM_PINS-1:0];

  always_comb begin
    dir_n  = dir_q;
    out_n  = out_q;
    ien_n  = ien_q;
    kind_n = kind_q;
    pol_n  = pol_q;
    both_n = both_q;
    clr_mask = '0;
    if (bus_wr_en) begin
      case (bus_addr)
        OFS_LEVEL: out_n    = wd;
        OFS_DIR:   dir_n    = wd;
        OFS_IEN:   ien_n    = wd;
        OFS_CLR:   clr_mask = wd;
        OFS_KIND:  kind_n   = wd;
        OFS_POL:   pol_n    = wd;
        OFS_BOTH:  both_n   = wd;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_LEVEL: rd_mux = BUS_W'((dir_q & lvl) | (~dir_q & out_q));
      OFS_DIR:   rd_mux = BUS_W'(dir_q);
      OFS_IEN:   rd_mux = BUS_W'(ien_q);
      OFS_STAT:  rd_mux = BUS_W'(status);
      OFS_PEND:  rd_mux = BUS_W'(pending);
      OFS_KIND:  rd_mux = BUS_W'(kind_q);
      OFS_POL:   rd_mux = BUS_W'(pol_q);
      OFS_VER:   rd_mux = BUS_W'(VERSION);
      OFS_BOTH:  rd_mux = BUS_W'(both_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      out_q   <= '0;
      ien_q   <= '0;
      kind_q  <= '1;
      pol_q   <= '1;
      both_q  <= '0;
      rdata_q <= '0;
    end else begin
      dir_q  <= dir_n;
      out_q  <= out_n;
      ien_q  <= ien_n;
      kind_q <= kind_n;
      pol_q  <= pol_n;
      both_q <= both_n;
      if (bus_rd_en) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign dir_in    = dir_q;
  assign out_lvl   = out_q;
  assign ien       = ien_q;
  assign kind_edge = kind_q;
  assign pol_high  = pol_q;
  assign both_edge = both_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int          NUM_PINS = 32,
  parameter int unsigned VERSION  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] lvl, lvl_prev, hit;
  logic [NUM_PINS-1:0] dir_in, out_lvl, ien, kind_edge, pol_high, both_edge;
  logic [NUM_PINS-1:0] clr_mask, status, pending;

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_trig (
    .lvl(lvl), .lvl_prev(lvl_prev), .kind_edge(kind_edge),
    .pol_high(pol_high), .both_edge(both_edge), .hit(hit)
  );

  gpio_irq_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_mask(clr_mask), .ien(ien),
    .status(status), .pending(pending), .irq(irq_o)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl(lvl), .status(status), .pending(pending),
    .dir_in(dir_in), .out_lvl(out_lvl), .ien(ien), .kind_edge(kind_edge),
    .pol_high(pol_high), .both_edge(both_edge), .clr_mask(clr_mask)
  );

  assign pin_out = out_lvl;
  assign pin_oe  = ~dir_in;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int          NUM_PINS = 32,
  parameter int unsigned VERSION  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr_en,
  input logic                bus_rd_en,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic [BUS_W-1:0]    bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq_o
);
  AST_DIR_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_DIR) |=> pin_oe == ~$past(bus_wdata[NUM_PINS-1:0])); // R2

  AST_OUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_LEVEL) |=> pin_out == $past(bus_wdata[NUM_PINS-1:0])); // R2

  AST_VERSION_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == OFS_VER) |=> bus_rdata == BUS_W'(VERSION)); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_IEN && bus_wdata[NUM_PINS-1:0] == '0) |=> !irq_o); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr > OFS_BOTH) |=> bus_rdata == '0); // R11
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int WATCHDOG = 20000;

  logic          clk;
  logic          rst_n;
  logic [5:0]    bus_addr;
  logic          bus_wr_en, bus_rd_en;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  gpio_irq_ctrl #(.NUM_PINS(NP), .VERSION(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1;
    @(negedge clk);
    bus_rd_en = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] act(input logic [NP-1:0] x, input bit pol);
    return pol ? x : ~x;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] st_pat [4];
    logic [NP-1:0] en_pat [4];
    rst_n = 0; bus_addr = 0; bus_wr_en = 0; bus_rd_en = 0; bus_wdata = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 irq_o", 32'(irq_o), 0);
    rd(6'h04, d); check("R1 dir", d, 32'hFF);
    rd(6'h08, d); check("R1 ien", d, 0);
    rd(6'h18, d); check("R1 kind", d, 32'hFF);
    rd(6'h1C, d); check("R1 pol", d, 32'hFF);
    rd(6'h24, d); check("R1 both", d, 0);
    rd(6'h0C, d); check("R1 status", d, 0);

    // R10: version and read-only offsets
    rd(6'h20, d); check("R10 version", d, 3);
    wr(6'h20, 32'h0); rd(6'h20, d); check("R10 version after write", d, 3);
    wr(6'h0C, 32'hFF); rd(6'h0C, d); check("R10 status write ignored", d, 0);
    wr(6'h10, 32'hFF); rd(6'h10, d); check("R10 pending write ignored", d, 0);

    // R11: unmapped addresses
    rd(6'h28, d); check("R11 unmapped 0x28", d, 0);
    rd(6'h02, d); check("R11 unaligned 0x02", d, 0);

    // R2 / R3: direction and value
    wr(6'h04, 32'h0F);
    check("R2 pin_oe", 32'(pin_oe), 32'hF0);
    wr(6'h00, 32'hA5);
    check("R2 pin_out", 32'(pin_out), 32'hA5);
    pin_in = 8'h3C; settle();
    rd(6'h00, d); check("R3 mixed value read", d, 32'((8'h0F & 8'h3C) | (8'hF0 & 8'hA5)));
    wr(6'h04, 32'hFF);
    rd(6'h00, d); check("R3 all-input read", d, 32'h3C);

    // R4 R5 R6: trigger sweep
    st_pat[0] = 8'h00; en_pat[0] = 8'hFF;
    st_pat[1] = 8'hFF; en_pat[1] = 8'h00;
    st_pat[2] = 8'h0F; en_pat[2] = 8'h3C;
    st_pat[3] = 8'hA5; en_pat[3] = 8'h5A;
    for (int m = 0; m < 6; m++) begin
      bit kind, pol, both;
      string tag;
      kind = (m >= 2); both = (m >= 4);
      pol  = (m == 0) || (m == 2) || (m == 4);
      tag  = (m < 2) ? "R4 level" : (m < 4) ? "R5 edge" : "R6 both";
      wr(6'h18, kind ? 32'hFF : 0);
      wr(6'h1C, pol ? 32'hFF : 0);
      wr(6'h24, both ? 32'hFF : 0);
      for (int p = 0; p < 4; p++) begin
        logic [NP-1:0] s, e, exp;
        s = st_pat[p]; e = en_pat[p];
        pin_in = s; settle();
        wr(6'h14, 32'hFF); settle();
        pin_in = e; settle();
        if (!kind)     exp = act(s, pol) | act(e, pol);
        else if (both) exp = s ^ e;
        else if (pol)  exp = ~s & e;
        else           exp = s & ~e;
        rd(6'h0C, d);
        check($sformatf("%s mode%0d pat%0d", tag, m, p), d, 32'(exp));
      end
    end

    // R7: clear semantics (rising-edge mode)
    wr(6'h18, 32'hFF); wr(6'h1C, 32'hFF); wr(6'h24, 0);
    pin_in = 0; settle(); wr(6'h14, 32'hFF);
    pin_in = 8'hFF; settle();
    wr(6'h14, 32'h0); rd(6'h0C, d); check("R7 zero write keeps", d, 32'hFF);
    wr(6'h14, 32'h0F); rd(6'h0C, d); check("R7 partial clear", d, 32'hF0);
    // R7: active level survives clear
    wr(6'h18, 32'h00); settle();
    wr(6'h14, 32'hFF); rd(6'h0C, d); check("R7 level still active", d, 32'hFF);
    pin_in = 8'h00; settle();
    wr(6'h14, 32'hFF); rd(6'h0C, d); check("R7 level gone clears", d, 32'h00);

    // R8: clear and new edge in the same cycle
    wr(6'h18, 32'hFF);
    pin_in = 8'h01; settle();           // status bit0 set
    pin_in = 8'h00; settle();           // falling: no hit in rising mode
    @(negedge clk); pin_in = 8'h01;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 6'h14; bus_wdata = 32'h01; bus_wr_en = 1;
    @(negedge clk); bus_wr_en = 0;
    rd(6'h0C, d); check("R8 edge wins over clear", d, 32'h01);
    wr(6'h14, 32'h01); rd(6'h0C, d); check("R8 plain clear", d, 32'h00);

    // R9: pending and irq across enable masks
    pin_in = 8'h00; settle(); wr(6'h14, 32'hFF);
    pin_in = 8'h96; settle();          // rising on pins 1,2,4,7
    for (int k = 0; k < 5; k++) begin
      logic [NP-1:0] en;
      en = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 : (k == 3) ? 8'hFF : 8'h69;
      wr(6'h08, 32'(en));
      rd(6'h10, d); check($sformatf("R9 pending en=%h", en), d, 32'(en & 8'h96));
      check($sformatf("R9 irq en=%h", en), 32'(irq_o), 32'(|(en & 8'h96)));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule